// File: doc/BRIEF.md
# Monotonic-Switching Successive-Approximation Bit Register

This block keeps the search state of a fully differential successive-approximation converter whose two capacitor arrays are switched monotonically. While the sampling level is high, every bottom-plate control line of both arrays is held at the high rail and the bit pointer is parked on the most significant bit. Once sampling ends, the first comparator decision is taken with nothing switched. Each later qualified decision pulls exactly one line low: the line of the bit under test, on the array whose input was judged more positive. Its twin on the other array stays high.

A decision is qualified when exactly one of the two comparator outputs is high, so a comparator that is still in reset (both low) or has failed (both high) is not counted. A one-hot pointer moves one place toward the least significant bit on every qualified decision and selects which bit latch captures it. One set of latches serves both arrays. When the least significant bit has been decided, the block raises end-of-conversion, gives a one-cycle done strobe and holds the code and every control line until the next sampling phase. Comparator activity during that hold is ignored.

Top module: `sar_mono_reg`

## Requirements
- R1: After reset, all `ctl_p` and `ctl_n` lines are 1 (high rail), `code` is 0, and `eoc` and `done` are 0.
- R2: While `sample` is 1, every `ctl_p` and `ctl_n` line is 1 from the next clock on, and `eoc` is 0. A high `sample` in the middle of a conversion discards it, and the next conversion starts again from the most significant bit.
- R3: After `sample` falls, all control lines stay at 1 until the first qualified decision, which is taken for bit N-1 (the most significant bit).
- R4: A qualified decision is a 0-to-1 transition of `cmp_p XOR cmp_n` seen at a clock edge while `sample` is 0. Each one changes exactly one control line, one clock later at most. If `cmp_p` is 1, `ctl_p[i]` goes to 0. Otherwise `ctl_n[i]` goes to 0. Here i is the bit under test.
- R5: If `cmp_p` and `cmp_n` are both 1, or both 0, nothing is decided and no control line changes.
- R6: Bits are decided in the order N-1, N-2, and so on down to 0, one per qualified decision. A `ctl_p`/`ctl_n` pair is never 0/0 at the same time.
- R7: `code[i]` is 1 exactly when the positive input was judged larger at step i. Otherwise it is 0, and it is 0 for bits not yet decided. With an ideal comparator the final code equals the input in offset binary.
- R8: In the clock cycle in which bit 0 is decided, `eoc` rises and `done` goes to 1 for exactly one cycle.
- R9: While `eoc` is 1 and `sample` is 0, further qualified decisions change no control line and no code bit, and `eoc` stays at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample | input | 1 | Sampling phase level. High means the inputs are being tracked |
| cmp_p | input | 1 | Comparator output; 1 means the positive input is larger |
| cmp_n | input | 1 | Comparator output; 1 means the negative input is larger |
| ctl_p | output | NBITS | Positive-array bottom-plate controls; 1 is the high rail, 0 is ground |
| ctl_n | output | NBITS | Negative-array bottom-plate controls; 1 is the high rail, 0 is ground |
| code | output | NBITS | Conversion result, valid while `eoc` is 1 |
| eoc | output | 1 | End of conversion, held until the next sampling phase |
| done | output | 1 | One-cycle strobe when the last bit is decided |

## Verification
The bench builds the block with its default of ten bits. At that width the full input range runs from -512 to +511. A comparator model in the bench forms its decision from the control lines the block drives, so a wrong line choice or a wrong order shows up as a wrong code. Both ends of the range, the two codes on either side of mid-scale and several random inputs are converted. Both-high comparator outputs, decisions after end of conversion and a sampling phase that cuts into an unfinished conversion are all driven at the ten-bit width.

// File: rtl/sar_mono_pkg.sv
`timescale 1ns/1ps
package sar_mono_pkg;
   localparam int SAR_DEFAULT_BITS = 10;
   localparam int SAR_MAX_BITS     = 32;

   typedef enum logic {
      PH_SEARCH = 1'b0,
      PH_HOLD   = 1'b1
   } sar_phase_e;
endpackage

// File: rtl/sar_mono_qualify.sv
`timescale 1ns/1ps
module sar_mono_qualify (
   input  logic clk,
   input  logic rst_n,
   input  logic sample,
   input  logic cmp_p,
   input  logic cmp_n,
   output logic step,
   output logic decision
);
   logic valid;
   logic valid_q;

   assign valid    = cmp_p ^ cmp_n;
   assign decision = cmp_p;
   assign step     = valid & ~valid_q & ~sample;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= 1'b0;
      else        valid_q <= valid;
   end

   // R5: outputs that agree never qualify a decision
   a_r5_no_step_on_tie: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_p == cmp_n) |-> !step);
endmodule

// File: rtl/sar_mono_pointer.sv
`timescale 1ns/1ps
module sar_mono_pointer
   import sar_mono_pkg::*;
#(
   parameter int NBITS = SAR_DEFAULT_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sample,
   input  logic             step,
   output logic [NBITS-1:0] ptr,
   output logic             go,
   output logic             eoc,
   output logic             done
);
   localparam logic [NBITS-1:0] PTR_START = {1'b1, {(NBITS-1){1'b0}}};

   sar_phase_e phase;

   assign go  = step & (phase == PH_SEARCH);
   assign eoc = (phase == PH_HOLD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr   <= PTR_START;
         phase <= PH_SEARCH;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (sample) begin
            ptr   <= PTR_START;
            phase <= PH_SEARCH;
         end else if (go) begin
            if (ptr[0]) begin
               phase <= PH_HOLD;
               done  <= 1'b1;
            end else begin
               ptr <= ptr >> 1;
            end
         end
      end
   end

   // R6: exactly one bit is ever under test
   a_r6_ptr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(ptr) == 1);
   // R8: strobe only together with end of conversion
   a_r8_done_in_eoc: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> eoc);
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R2: sampling reopens the search from the top bit
   a_r2_sample_rearms: assert property (@(posedge clk) disable iff (!rst_n)
      sample |=> (!eoc && ptr[NBITS-1]));
endmodule

// File: rtl/sar_mono_bit.sv
`timescale 1ns/1ps
module sar_mono_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic sample,
   input  logic capture,
   input  logic decision,
   output logic line_p,
   output logic line_n
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_p <= 1'b1;
         line_n <= 1'b1;
      end else if (sample) begin
         line_p <= 1'b1;
         line_n <= 1'b1;
      end else if (capture) begin
         line_p <= ~decision;
         line_n <= decision;
      end
   end

   // R2: sampling returns both plates to the high rail
   a_r2_rail_high: assert property (@(posedge clk) disable iff (!rst_n)
      sample |=> (line_p && line_n));
   // R6: never both plates grounded
   a_r6_not_both_low: assert property (@(posedge clk) disable iff (!rst_n)
      (line_p || line_n));
endmodule

// File: rtl/sar_mono_reg.sv
`timescale 1ns/1ps
module sar_mono_reg
   import sar_mono_pkg::*;
#(
   parameter int NBITS = SAR_DEFAULT_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sample,
   input  logic             cmp_p,
   input  logic             cmp_n,
   output logic [NBITS-1:0] ctl_p,
   output logic [NBITS-1:0] ctl_n,
   output logic [NBITS-1:0] code,
   output logic             eoc,
   output logic             done
);
   localparam int LINES = 2 * NBITS;

   initial begin
      assert (NBITS >= 2 && NBITS <= SAR_MAX_BITS)
         else $error("sar_mono_reg: NBITS out of range");
   end

   logic             step;
   logic             decision;
   logic             go;
   logic [NBITS-1:0] ptr;

   sar_mono_qualify u_qual (
      .clk      (clk),
      .rst_n    (rst_n),
      .sample   (sample),
      .cmp_p    (cmp_p),
      .cmp_n    (cmp_n),
      .step     (step),
      .decision (decision)
   );

   sar_mono_pointer #(.NBITS(NBITS)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .sample (sample),
      .step   (step),
      .ptr    (ptr),
      .go     (go),
      .eoc    (eoc),
      .done   (done)
   );

   for (genvar i = 0; i < NBITS; i++) begin : g_bit
      sar_mono_bit u_bit (
         .clk      (clk),
         .rst_n    (rst_n),
         .sample   (sample),
         .capture  (go & ptr[i]),
         .decision (decision),
         .line_p   (ctl_p[i]),
         .line_n   (ctl_n[i])
      );
      assign code[i] = ~ctl_p[i];
   end

   logic [LINES-1:0] lines;
   assign lines = {ctl_p, ctl_n};

   // R4: each qualified decision moves exactly one line
   a_r4_one_line: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !sample) |=> ($countones(lines ^ $past(lines)) == 1));
   // R4: outside of sampling, at most one line moves per cycle
   a_r4_at_most_one: assert property (@(posedge clk) disable iff (!rst_n)
      !sample |=> ($countones(lines ^ $past(lines)) <= 1));
   // R9: the result is frozen after end of conversion
   a_r9_hold_after_eoc: assert property (@(posedge clk) disable iff (!rst_n)
      (eoc && !sample) |=> ($stable(lines) && eoc));
   // R8: end of conversion comes with the strobe
   a_r8_rise_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eoc) |-> done);
endmodule

// File: tb/test_sar_mono_reg.sv
`timescale 1ns/1ps
module test_sar_mono_reg;
   localparam int CLK_PERIOD = 10;
   localparam int N          = 10;
   localparam int HALF       = 1 << (N - 1);

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sample = 1'b1;
   logic         cmp_p = 1'b0;
   logic         cmp_n = 1'b0;
   logic [N-1:0] ctl_p, ctl_n, code;
   logic         eoc, done;

   int n_chk = 0;
   int n_bad = 0;

   sar_mono_reg #(.NBITS(N)) i_sar_mono_reg (
      .clk(clk), .rst_n(rst_n), .sample(sample), .cmp_p(cmp_p), .cmp_n(cmp_n),
      .ctl_p(ctl_p), .ctl_n(ctl_n), .code(code), .eoc(eoc), .done(done)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   // ideal differential comparator fed by the block's own plate controls
   function automatic bit model_cmp(input int x);
      int d = 2 * x + 1;
      for (int j = 1; j < N; j++) begin
         if (!ctl_p[j]) d -= (1 << j);
         if (!ctl_n[j]) d += (1 << j);
      end
      return d > 0;
   endfunction

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic begin_sampling();
      sample = 1'b1; cmp_p = 1'b0; cmp_n = 1'b0;
      tick(); tick();
      chk("R2 ctl_p high while sampling", ctl_p, {N{1'b1}});
      chk("R2 ctl_n high while sampling", ctl_n, {N{1'b1}});
      chk("R2 eoc low while sampling", eoc, 0);
      sample = 1'b0;
      tick(); tick();
      chk("R3 nothing switched before MSB", {ctl_p, ctl_n}, {2*N{1'b1}});
   endtask

   // one decision for bit i; returns after the comparator is back to reset
   task automatic decide(input int x, input int i);
      logic [N-1:0] pp, pn;
      bit d;
      pp = ctl_p; pn = ctl_n;
      d = model_cmp(x);
      cmp_p = d; cmp_n = ~d;
      tick();
      chk("R4 target positive line", ctl_p[i], d ? 0 : 1);
      chk("R4 target negative line", ctl_n[i], d ? 1 : 0);
      chk("R4 one line per decision", $countones({ctl_p ^ pp, ctl_n ^ pn}), 1);
      chk("R7 code bit matches decision", code[i], d);
      if (i == 0) begin
         chk("R8 done strobe on last bit", done, 1);
         chk("R8 eoc on last bit", eoc, 1);
      end else begin
         chk("R6 no eoc before last bit", eoc, 0);
      end
      cmp_p = 1'b0; cmp_n = 1'b0;
      tick();
      if (i == 0) chk("R8 done lasts one cycle", done, 0);
   endtask

   task automatic t_convert(input int x);
      begin_sampling();
      for (int i = N - 1; i >= 0; i--) decide(x, i);
      chk($sformatf("R7 final code x=%0d", x), code, x + HALF);
      chk("R8 eoc held", eoc, 1);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; sample = 1'b0;
      tick(); tick();
      chk("R1 reset ctl_p", ctl_p, {N{1'b1}});
      chk("R1 reset ctl_n", ctl_n, {N{1'b1}});
      chk("R1 reset code", code, 0);
      chk("R1 reset eoc", eoc, 0);
      chk("R1 reset done", done, 0);
      rst_n = 1'b1;
      tick();
   endtask

   task automatic t_tie(input int x);
      logic [2*N-1:0] snap;
      begin_sampling();
      for (int i = N - 1; i >= 0; i--) begin
         if (i == N - 3) begin
            snap = {ctl_p, ctl_n};
            cmp_p = 1'b1; cmp_n = 1'b1;
            tick(); tick();
            chk("R5 both high ignored", {ctl_p, ctl_n}, snap);
            cmp_p = 1'b0; cmp_n = 1'b0;
            tick();
            chk("R5 both low ignored", {ctl_p, ctl_n}, snap);
         end
         decide(x, i);
      end
      chk("R5 code after tie pulses", code, x + HALF);
   endtask

   task automatic t_after_eoc(input int x);
      logic [3*N-1:0] snap;
      t_convert(x);
      snap = {ctl_p, ctl_n, code};
      for (int k = 0; k < 3; k++) begin
         cmp_p = k[0]; cmp_n = ~k[0];
         tick();
         cmp_p = 1'b0; cmp_n = 1'b0;
         tick();
      end
      chk("R9 lines and code frozen", {ctl_p, ctl_n, code}, snap);
      chk("R9 eoc stays high", eoc, 1);
      chk("R9 no extra done", done, 0);
   endtask

   task automatic t_restart(input int x1, input int x2);
      begin_sampling();
      for (int i = N - 1; i >= N - 4; i--) decide(x1, i);
      sample = 1'b1;
      tick();
      chk("R2 restart lines high", {ctl_p, ctl_n}, {2*N{1'b1}});
      chk("R2 restart eoc low", eoc, 0);
      t_convert(x2);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_bad++;
      $display("FAIL watchdog R8 actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      tick();
      t_reset();
      t_convert(0);
      t_convert(-1);
      t_convert(HALF - 1);
      t_convert(-HALF);
      t_convert(341);
      t_convert(-170);
      for (int k = 0; k < 6; k++) begin
         int r = int'($urandom_range(2 * HALF - 1, 0)) - HALF;
         t_convert(r);
      end
      t_tie(-300);
      t_after_eoc(77);
      t_restart(200, -33);
      summary();
      $finish;
   end
endmodule